// File: doc/BRIEF.md
# DDR Refresh Scheduler

This block decides when a DDR SDRAM controller must spend a command slot on an auto-refresh. A free-running interval timer adds one unit of refresh credit each time an average refresh period elapses. Credit builds up in a pending counter that stops at eight. The block raises a request toward the command arbiter while credit is available. The arbiter may let that credit accumulate. Once the counter is full, an urgent flag tells the arbiter that the refresh must win over all other traffic. A grant is taken only while every bank is reported idle. Each accepted refresh closes a recovery window of tRFC before the next refresh or any activate.

The same block handles self refresh. While the self-refresh request is high and the banks are idle, the block enters self refresh, and the memory then refreshes itself. During self refresh the pending credit is cleared and the interval timer holds its count. When the request drops, the block leaves self refresh and keeps two separate gates closed: activates (and refreshes) wait a nanosecond-based exit delay, and reads wait a longer delay counted in clocks. All delays are given in picoseconds or clocks and converted to clocks at elaboration.

Top module: `ddr_refresh_sched`

## Requirements
- R1: After reset, ref_req, ref_urgent and sr_active are 0, pend_cnt is 0, and act_ok and rd_ok are 1.
- R2: Outside self refresh, pend_cnt rises by one every INTERVAL clocks (REFI_PS / CLK_PERIOD_PS). The first increment shows exactly INTERVAL clocks after reset is released.
- R3: pend_cnt never exceeds MAX_PEND (8). An interval that ends while the count is full is dropped.
- R4: ref_urgent is 1 exactly while pend_cnt equals MAX_PEND.
- R5: ref_req is 1 only when all of these hold: pend_cnt is nonzero, no refresh recovery is running, the exit-to-activate delay has expired, and the block is out of self refresh.
- R6: A refresh is accepted on a clock where ref_req, ref_gnt and banks_idle are all 1. An accepted refresh lowers pend_cnt by one. A grant while banks_idle is 0 has no effect.
- R7: After an accepted refresh, ref_req and act_ok stay 0 for RFC clocks (ceil of RFC_PS / CLK_PERIOD_PS). They return to 1 on the RFC-th clock after the acceptance, so consecutive refreshes are at least RFC clocks apart.
- R8: Self refresh is entered one clock after the clock edge at which sr_req and banks_idle are both 1, no refresh recovery is running, and no refresh is accepted on that edge. On entry pend_cnt becomes 0. While sr_active is 1, ref_req, act_ok and rd_ok are 0.
- R9: During self refresh the interval timer holds its count, so pend_cnt stays 0. After exit the timer continues from the held count.
- R10: When sr_req is 0 during self refresh, sr_active falls at the next clock. act_ok then stays 0 for XS_ACT clocks (ceil of XS_ACT_PS / CLK_PERIOD_PS), and rd_ok stays 0 for XS_RD_CLKS clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| banks_idle | input | 1 | All banks precharged; a refresh or self-refresh entry may be taken |
| ref_gnt | input | 1 | Arbiter grants the refresh command slot |
| sr_req | input | 1 | Hold high to be in self refresh, drop to leave it |
| ref_req | output | 1 | Refresh credit available and timing allows a refresh |
| ref_urgent | output | 1 | Pending credit is full; refresh must be granted first |
| pend_cnt | output | $clog2(MAX_PEND+1) | Number of postponed refreshes |
| sr_active | output | 1 | Memory is in self refresh |
| act_ok | output | 1 | An activate may be issued |
| rd_ok | output | 1 | A read may be issued |

## Verification
Two kinds of internal fault show up at the ports. A credit counter that miscounts or wraps appears on pend_cnt and ref_urgent within one refresh interval. It is caught by checking the exact clock of each increment, including the saturation interval. A recovery or exit timer loaded with the wrong value moves the edge of ref_req, act_ok or rd_ok by that many clocks, so the scoreboard checks those edges one clock before and at the expected clock. A timer that fails to freeze in self refresh, or fails to clear on entry, gives an early or nonzero pend_cnt in the clocks right after exit.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;

   typedef enum logic [0:0] {
      SR_OFF  = 1'b0,
      SR_HELD = 1'b1
   } sr_mode_e;

   // width able to hold values 0..n
   function automatic int cntw(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   // ceiling division used for ns-to-clock conversion
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/ddr_ref_dncnt.sv
// Loadable down-counter; zero is high when the window has expired.
module ddr_ref_dncnt
   import ddr_ref_pkg::*;
#(
   parameter int LOAD_VAL = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic zero
);

   localparam int W = cntw(LOAD_VAL);

   if (LOAD_VAL < 1) begin : g_bad_load
      $error("ddr_ref_dncnt: LOAD_VAL must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= W'(LOAD_VAL);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_ref_tick.sv
// Interval timer: pulses once every INTERVAL running clocks, holds while run is low.
module ddr_ref_tick
   import ddr_ref_pkg::*;
#(
   parameter int INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   localparam int LAST = INTERVAL - 1;
   localparam int W    = cntw(LAST);

   if (INTERVAL < 2) begin : g_bad_interval
      $error("ddr_ref_tick: INTERVAL must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic         at_end;

   assign at_end = (cnt_q == W'(LAST));
   assign tick   = run && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (run)    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/ddr_ref_credit.sv
// Saturating pending-refresh counter with synchronous clear.
module ddr_ref_credit
   import ddr_ref_pkg::*;
#(
   parameter int MAX_PEND = 8,
   localparam int W = cntw(MAX_PEND)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   input  logic         clr,
   output logic [W-1:0] count,
   output logic         full
);

   if (MAX_PEND < 1) begin : g_bad_max
      $error("ddr_ref_credit: MAX_PEND must be at least 1");
   end

   logic [W-1:0] cnt_q;

   assign full  = (cnt_q == W'(MAX_PEND));
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else begin
         unique case ({inc, dec})
            2'b10:   if (!full)         cnt_q <= cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/ddr_ref_srctl.sv
// Self-refresh mode tracker with entry and exit pulses.
module ddr_ref_srctl
   import ddr_ref_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sr_req,
   input  logic can_enter,
   output logic sr_on,
   output logic enter_p,
   output logic exit_p
);

   sr_mode_e mode_q;

   assign enter_p = (mode_q == SR_OFF)  &&  sr_req && can_enter;
   assign exit_p  = (mode_q == SR_HELD) && !sr_req;
   assign sr_on   = (mode_q == SR_HELD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= SR_OFF;
      else if (enter_p) mode_q <= SR_HELD;
      else if (exit_p)  mode_q <= SR_OFF;
   end

endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
   import ddr_ref_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 5000,
   parameter int REFI_PS       = 7_800_000,
   parameter int RFC_PS        = 70_000,
   parameter int XS_ACT_PS     = 70_000,
   parameter int XS_RD_CLKS    = 200,
   parameter int MAX_PEND      = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      banks_idle,
   input  logic                      ref_gnt,
   input  logic                      sr_req,
   output logic                      ref_req,
   output logic                      ref_urgent,
   output logic [cntw(MAX_PEND)-1:0] pend_cnt,
   output logic                      sr_active,
   output logic                      act_ok,
   output logic                      rd_ok
);

   localparam int INTERVAL_CLKS = REFI_PS / CLK_PERIOD_PS;
   localparam int RFC_CLKS      = ceil_div(RFC_PS, CLK_PERIOD_PS);
   localparam int XS_ACT_CLKS   = ceil_div(XS_ACT_PS, CLK_PERIOD_PS);
   localparam int N_XS          = 2;   // index 0: activate gate, 1: read gate

   if (CLK_PERIOD_PS < 1) begin : g_bad_clk
      $error("ddr_refresh_sched: CLK_PERIOD_PS must be positive");
   end
   if (INTERVAL_CLKS <= RFC_CLKS) begin : g_bad_ratio
      $error("ddr_refresh_sched: refresh interval must exceed tRFC");
   end

   logic            tick;
   logic            rfc_done;
   logic            accept;
   logic            can_enter;
   logic            sr_on;
   logic            enter_p;
   logic            exit_p;
   logic            full;
   logic [N_XS-1:0] xs_done;

   // interval timer frozen during self refresh
   ddr_ref_tick #(.INTERVAL(INTERVAL_CLKS)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (!sr_on),
      .tick  (tick)
   );

   // postponed-refresh credit
   ddr_ref_credit #(.MAX_PEND(MAX_PEND)) u_credit (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (tick),
      .dec   (accept),
      .clr   (enter_p),
      .count (pend_cnt),
      .full  (full)
   );

   // refresh recovery window
   ddr_ref_dncnt #(.LOAD_VAL(RFC_CLKS)) u_rfc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .zero  (rfc_done)
   );

   // self-refresh exit gates, one per command class
   for (genvar gi = 0; gi < N_XS; gi++) begin : g_xs
      ddr_ref_dncnt #(.LOAD_VAL(gi == 0 ? XS_ACT_CLKS : XS_RD_CLKS)) u_xs (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (exit_p),
         .zero  (xs_done[gi])
      );
   end

   ddr_ref_srctl u_sr (
      .clk       (clk),
      .rst_n     (rst_n),
      .sr_req    (sr_req),
      .can_enter (can_enter),
      .sr_on     (sr_on),
      .enter_p   (enter_p),
      .exit_p    (exit_p)
   );

   assign ref_req    = !sr_on && (pend_cnt != '0) && rfc_done && xs_done[0];
   assign accept     = ref_req && ref_gnt && banks_idle;
   assign can_enter  = banks_idle && rfc_done && !accept;
   assign ref_urgent = full;
   assign sr_active  = sr_on;
   assign act_ok     = !sr_on && rfc_done && xs_done[0];
   assign rd_ok      = !sr_on && xs_done[1];

endmodule

// File: rtl/ddr_ref_sched_chk.sv
module ddr_ref_sched_chk
   import ddr_ref_pkg::*;
#(
   parameter int MAX_PEND = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      banks_idle,
   input logic                      ref_gnt,
   input logic                      sr_req,
   input logic                      ref_req,
   input logic                      ref_urgent,
   input logic [cntw(MAX_PEND)-1:0] pend_cnt,
   input logic                      sr_active,
   input logic                      act_ok,
   input logic                      rd_ok
);

   p_pend_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= MAX_PEND);

   p_urgent_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_urgent) |-> $past(pend_cnt) == MAX_PEND - 1);

   p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> (pend_cnt != 0) && !sr_active && act_ok);

   p_idle_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_gnt && !banks_idle) |=> pend_cnt >= $past(pend_cnt));

   p_recovery_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && ref_gnt && banks_idle) |=> (!ref_req && !act_ok));

   p_sr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_active |-> (!ref_req && !act_ok && !rd_ok));

   p_sr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_active) |-> pend_cnt == 0);

   p_sr_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sr_active |=> pend_cnt == 0);

   p_exit_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_active) |-> (!act_ok && !rd_ok));

endmodule

bind ddr_refresh_sched ddr_ref_sched_chk #(.MAX_PEND(MAX_PEND)) u_chk (.*);

// File: tb/tb_ddr_refresh_sched.sv
module tb_ddr_refresh_sched;

   // 250 MHz: 4000 ps period; scaled timing for a short run
   localparam int CLK_PS  = 4000;
   localparam int INTV    = 20;   // 80000 / 4000
   localparam int RFC     = 3;    // 12000 / 4000
   localparam int XSA     = 5;    // 20000 / 4000
   localparam int XSR     = 12;
   localparam int MAXP    = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       banks_idle = 1'b1;
   logic       ref_gnt = 1'b0;
   logic       sr_req = 1'b0;
   logic       ref_req, ref_urgent, sr_active, act_ok, rd_ok;
   logic [3:0] pend_cnt;

   ddr_refresh_sched #(
      .CLK_PERIOD_PS (CLK_PS),
      .REFI_PS       (80_000),
      .RFC_PS        (12_000),
      .XS_ACT_PS     (20_000),
      .XS_RD_CLKS    (XSR),
      .MAX_PEND      (MAXP)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .banks_idle (banks_idle),
      .ref_gnt    (ref_gnt),
      .sr_req     (sr_req),
      .ref_req    (ref_req),
      .ref_urgent (ref_urgent),
      .pend_cnt   (pend_cnt),
      .sr_active  (sr_active),
      .act_ok     (act_ok),
      .rd_ok      (rd_ok)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   localparam int S_REQ = 0, S_URG = 1, S_PEND = 2, S_SR = 3, S_ACT = 4, S_RD = 5;

   typedef struct {
      int    due;
      int    sig;
      int    exp;
      string req;
   } exp_t;

   exp_t sb[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   function automatic int sample(input int sig);
      case (sig)
         S_REQ:   return int'(ref_req);
         S_URG:   return int'(ref_urgent);
         S_PEND:  return int'(pend_cnt);
         S_SR:    return int'(sr_active);
         S_ACT:   return int'(act_ok);
         default: return int'(rd_ok);
      endcase
   endfunction

   function automatic string sname(input int sig);
      case (sig)
         S_REQ:   return "ref_req";
         S_URG:   return "ref_urgent";
         S_PEND:  return "pend_cnt";
         S_SR:    return "sr_active";
         S_ACT:   return "act_ok";
         default: return "rd_ok";
      endcase
   endfunction

   // driver side: push expected item due after edge number 'due'
   task automatic expect_at(input int due, input int sig, input int val, input string req);
      exp_t e;
      e.due = due; e.sig = sig; e.exp = val; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: compare at the falling edge after the due rising edge
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            int act;
            act = sample(sb[i].sig);
            n_chk++;
            if (act != sb[i].exp) begin
               n_fail++;
               $display("FAIL %s: %s at edge %0d actual=%0d expected=%0d",
                        sb[i].req, sname(sb[i].sig), cyc, act, sb[i].exp);
            end
            sb.delete(i);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      int r0, x0, z0;
      step(3);
      rst_n = 1'b1;
      r0 = cyc;

      // R1 reset state
      expect_at(r0, S_REQ,  0, "R1");
      expect_at(r0, S_URG,  0, "R1");
      expect_at(r0, S_PEND, 0, "R1");
      expect_at(r0, S_SR,   0, "R1");
      expect_at(r0, S_ACT,  1, "R1");
      expect_at(r0, S_RD,   1, "R1");

      // R2 interval accrual, R5 request needs credit
      expect_at(r0 + INTV - 1, S_PEND, 0, "R2");
      expect_at(r0 + INTV - 1, S_REQ,  0, "R5");
      expect_at(r0 + INTV,     S_PEND, 1, "R2");
      expect_at(r0 + INTV,     S_REQ,  1, "R5");
      expect_at(r0 + 2*INTV,   S_PEND, 2, "R2");

      // R4 urgent at full count
      expect_at(r0 + 7*INTV, S_PEND, 7, "R4");
      expect_at(r0 + 7*INTV, S_URG,  0, "R4");
      expect_at(r0 + 8*INTV, S_PEND, 8, "R4");
      expect_at(r0 + 8*INTV, S_URG,  1, "R4");

      // R3 saturation after another interval
      expect_at(r0 + 9*INTV + 1, S_PEND, 8, "R3");
      expect_at(r0 + 9*INTV + 1, S_URG,  1, "R3");

      x0 = r0 + 9*INTV + 2;
      step(x0 - cyc);

      // R6 grant while banks busy is ignored
      ref_gnt = 1'b1;
      banks_idle = 1'b0;
      expect_at(x0 + 1, S_PEND, 8, "R6");
      expect_at(x0 + 1, S_REQ,  1, "R6");
      step(1);
      banks_idle = 1'b1;

      // R6 accept, R7 recovery spacing
      expect_at(x0 + 2, S_PEND, 7, "R6");
      expect_at(x0 + 2, S_URG,  0, "R4");
      expect_at(x0 + 2, S_REQ,  0, "R7");
      expect_at(x0 + 2, S_ACT,  0, "R7");
      expect_at(x0 + 4, S_REQ,  0, "R7");
      expect_at(x0 + 4, S_ACT,  0, "R7");
      expect_at(x0 + 5, S_REQ,  1, "R7");
      expect_at(x0 + 5, S_ACT,  1, "R7");
      expect_at(x0 + 5, S_PEND, 7, "R7");
      expect_at(x0 + 6, S_PEND, 6, "R7");
      expect_at(x0 + 6, S_REQ,  0, "R7");
      step(5);
      ref_gnt = 1'b0;

      // R8 entry waits for recovery, then clears credit
      step(1);
      sr_req = 1'b1;
      expect_at(x0 + 9,  S_SR,   0, "R8");
      expect_at(x0 + 10, S_SR,   1, "R8");
      expect_at(x0 + 10, S_PEND, 0, "R8");
      expect_at(x0 + 10, S_REQ,  0, "R8");
      expect_at(x0 + 10, S_ACT,  0, "R8");
      expect_at(x0 + 10, S_RD,   0, "R8");

      z0 = x0 + 60;
      step(z0 - cyc);
      sr_req = 1'b0;

      // R9 timer frozen: no credit during self refresh, resumes after exit
      expect_at(z0,     S_PEND, 0, "R9");
      expect_at(z0,     S_SR,   1, "R9");
      expect_at(z0 + 8, S_PEND, 0, "R9");
      expect_at(z0 + 9, S_PEND, 1, "R9");
      expect_at(z0 + 9, S_REQ,  1, "R9");

      // R10 exit delays
      expect_at(z0 + 1,  S_SR,  0, "R10");
      expect_at(z0 + 1,  S_ACT, 0, "R10");
      expect_at(z0 + 1,  S_RD,  0, "R10");
      expect_at(z0 + 5,  S_ACT, 0, "R10");
      expect_at(z0 + 6,  S_ACT, 1, "R10");
      expect_at(z0 + 12, S_RD,  0, "R10");
      expect_at(z0 + 13, S_RD,  1, "R10");

      step(20);
      if (sb.size() != 0) begin
         n_fail += sb.size();
         $display("FAIL scoreboard: %0d items unchecked actual=%0d expected=0",
                  sb.size(), sb.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (R1..): run hung actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule